// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the control logic of a small serial EEPROM with an 8-kbit array. A host selects it with a chip-select line and clocks bits in on a serial data input. Each command begins with a start bit, which is a data-in value of one sampled while select is high. An opcode and an address field follow. For the two write-type commands, a data word follows the address. Reads return the addressed word and then keep streaming the following words for as long as the host keeps clocking. The word size is 8 or 16 bits, chosen by a width-select input.

Programming commands are gated twice. A write-enable latch is cleared at reset and is set or cleared by two special commands. A program-enable input blocks every change to the array while it is low. An accepted programming command starts a self-timed cycle with a length given by a parameter. If the host raises select again afterwards, the data output shows the state of that cycle: low while busy, high when ready.

All pins are sampled by the system clock `clk_i`. A serial edge is a clock cycle in which `sck_i` is high and was low in the previous cycle.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While select is high and no start bit has been seen, serial edges with data-in low change nothing, and the data output stays released.
- R2: After the start bit, 2 opcode bits and an address field are shifted in MSB first. The opcodes are 10 = READ, 01 = WRITE, 11 = ERASE and 00 = special. The address field is 11 bits wide in 8-bit mode and 10 bits wide in 16-bit mode, and its top bit is ignored. For special commands, the two top field bits choose the command: 11 = enable writes, 00 = disable writes, 10 = erase all, 01 = write all. Write data follows MSB first.
- R3: On the serial edge that samples the last address bit of a READ, the output is driven with a dummy 0. On each following edge, the output presents the next data bit, MSB first. Words continue at the next sequential address and wrap from the last address to address 0.
- R4: Width-select high gives 16-bit words 0..511. Word w holds byte 2w as its upper half and byte 2w+1 as its lower half. Width-select low gives bytes 0..1023.
- R5: After reset, writes are disabled. Enable-writes and disable-writes set and clear the latch. While the latch is clear, WRITE, ERASE, erase-all and write-all leave the array unchanged.
- R6: While program-enable is low, no programming command changes the array or starts a cycle.
- R7: A command whose last required bit has not been clocked in before select falls has no effect.
- R8: Select low releases the data output and resets the command decoder to wait for a start bit.
- R9: An accepted programming command keeps the device busy for PROG_CYCLES clock cycles, whatever select and the serial clock do. Programming commands that arrive while busy are ignored.
- R10: After a cycle has been started, raising select without a start bit drives the output low while busy and high once ready. A start bit followed by select falling removes this status.
- R11: After reset, every location reads as all ones. ERASE and erase-all set the affected locations to all ones. Write-all sets every word to the supplied data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all pins |
| rst_ni | input | 1 | Active-low reset (power-up) |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word width select: 1 = 16-bit, 0 = 8-bit |
| pe_i | input | 1 | Program enable, active high |
| do_o | output | 1 | Serial data out / ready-busy status |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The assertions check on every cycle that the output is released whenever select is low, and that the decoder returns to its idle state after select falls. They also check that every read begins with a dummy zero, that a busy period starts only when the enable latch and the program-enable pin both allowed it, and that the cycle counter stays inside its range. The bench scenarios are the only way to show the rest. This covers data landing at the right byte in each width mode, sequential wrap-around, and commands being abandoned when select falls early. It also covers writes refused while busy or disabled, and the busy-then-ready status with its clearing by a start bit.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;

  localparam logic [1:0] SUB_WDIS  = 2'b00;
  localparam logic [1:0] SUB_FILL  = 2'b01;
  localparam logic [1:0] SUB_CLEAR = 2'b10;
  localparam logic [1:0] SUB_WEN   = 2'b11;

  typedef enum logic [2:0] {
    K_NONE, K_WRITE, K_ERASE, K_CLEAR, K_FILL, K_WEN, K_WDIS
  } cmd_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_READ, S_DONE
  } fr_state_t;

  function automatic cmd_kind_t kind_of(input logic [1:0] op, input logic [1:0] sub);
    case (op)
      OPC_WRITE: kind_of = K_WRITE;
      OPC_ERASE: kind_of = K_ERASE;
      OPC_SPECIAL: begin
        case (sub)
          SUB_WEN:   kind_of = K_WEN;
          SUB_WDIS:  kind_of = K_WDIS;
          SUB_CLEAR: kind_of = K_CLEAR;
          default:   kind_of = K_FILL;
        endcase
      end
      default: kind_of = K_NONE;
    endcase
  endfunction

  function automatic logic needs_data(input cmd_kind_t k);
    needs_data = (k == K_WRITE) || (k == K_FILL);
  endfunction

  function automatic logic is_prog(input cmd_kind_t k);
    is_prog = (k == K_WRITE) || (k == K_ERASE) || (k == K_CLEAR) || (k == K_FILL);
  endfunction
endpackage

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ABITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sck_rise_i,
  input  logic             di_i,
  input  logic             org_i,
  input  logic [15:0]      rd_word_i,
  output logic             start_o,
  output logic             cmd_stb_o,
  output cmd_kind_t        cmd_kind_o,
  output logic [ABITS-1:0] cmd_addr_o,
  output logic [15:0]      cmd_data_o,
  output logic [ABITS-1:0] rd_addr_o,
  output logic             rd_active_o,
  output logic             rd_bit_o,
  output logic             idle_o
);
  localparam int HW = ABITS + 3;
  localparam logic [ABITS-1:0] WMASK = {1'b0, {(ABITS-1){1'b1}}};

  fr_state_t        st;
  logic [4:0]       cnt;
  logic [HW-1:0]    hdr;
  logic [15:0]      dat;
  logic [3:0]       rd_cnt;

  // header field extraction, parameterised by width mode
  function automatic logic [1:0] f_op(input logic [HW-1:0] h, input logic o);
    f_op = o ? h[ABITS+1:ABITS] : h[ABITS+2:ABITS+1];
  endfunction
  function automatic logic [1:0] f_sub(input logic [HW-1:0] h, input logic o);
    f_sub = o ? h[ABITS-1:ABITS-2] : h[ABITS:ABITS-1];
  endfunction
  function automatic logic [ABITS-1:0] f_addr(input logic [HW-1:0] h, input logic o);
    f_addr = o ? {1'b0, h[ABITS-2:0]} : h[ABITS-1:0];
  endfunction

  logic [HW-1:0]    hdr_nx;
  logic [15:0]      dat_nx;
  logic [4:0]       hdr_last, dat_last;
  logic [3:0]       dw_m1;
  logic [1:0]       hdr_op;
  cmd_kind_t        hdr_kind;
  logic [ABITS-1:0] hdr_addr;
  logic [ABITS-1:0] rd_next;

  always_comb begin
    hdr_nx   = {hdr[HW-2:0], di_i};
    dat_nx   = {dat[14:0], di_i};
    hdr_last = org_i ? 5'(ABITS + 1) : 5'(ABITS + 2);
    dat_last = org_i ? 5'd15 : 5'd7;
    dw_m1    = org_i ? 4'd15 : 4'd7;
    hdr_op   = f_op(hdr_nx, org_i);
    hdr_kind = kind_of(hdr_op, f_sub(hdr_nx, org_i));
    hdr_addr = f_addr(hdr_nx, org_i);
    rd_next  = org_i ? ((rd_addr_o + 1'b1) & WMASK) : (rd_addr_o + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= S_IDLE;
      cnt         <= '0;
      hdr         <= '0;
      dat         <= '0;
      rd_cnt      <= '0;
      rd_addr_o   <= '0;
      rd_bit_o    <= 1'b0;
      start_o     <= 1'b0;
      cmd_stb_o   <= 1'b0;
      cmd_kind_o  <= K_NONE;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      start_o   <= 1'b0;
      cmd_stb_o <= 1'b0;
      if (!cs_i) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (sck_rise_i) begin
        case (st)
          S_IDLE: if (di_i) begin
            st      <= S_HDR;
            cnt     <= '0;
            hdr     <= '0;
            start_o <= 1'b1;
          end
          S_HDR: begin
            hdr <= hdr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == hdr_last) begin
              cnt <= '0;
              if (hdr_op == OPC_READ) begin
                st        <= S_READ;
                rd_addr_o <= hdr_addr;
                rd_cnt    <= '0;
                rd_bit_o  <= 1'b0;
              end else begin
                cmd_kind_o <= hdr_kind;
                cmd_addr_o <= hdr_addr;
                if (needs_data(hdr_kind)) begin
                  st  <= S_DATA;
                  dat <= '0;
                end else begin
                  st        <= S_DONE;
                  cmd_stb_o <= 1'b1;
                end
              end
            end
          end
          S_DATA: begin
            dat <= dat_nx;
            cnt <= cnt + 1'b1;
            if (cnt == dat_last) begin
              cmd_data_o <= org_i ? dat_nx : {8'h00, dat_nx[7:0]};
              cmd_stb_o  <= 1'b1;
              st         <= S_DONE;
            end
          end
          S_READ: begin
            rd_bit_o <= rd_word_i[dw_m1 - rd_cnt];
            if (rd_cnt == dw_m1) begin
              rd_cnt    <= '0;
              rd_addr_o <= rd_next;
            end else begin
              rd_cnt <= rd_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active_o = (st == S_READ);
  assign idle_o      = (st == S_IDLE);

  AST_DESEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> idle_o); // R8
  AST_READ_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active_o) |-> !rd_bit_o); // R3
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int ABITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             org_i,
  input  logic             we_i,
  input  cmd_kind_t        kind_i,
  input  logic [ABITS-1:0] addr_i,
  input  logic [15:0]      data_i,
  input  logic [ABITS-1:0] rd_addr_i,
  output logic [15:0]      rd_word_o
);
  localparam int NBYTES = 1 << ABITS;

  logic [7:0] mem [NBYTES];

  // 16-bit word w: upper byte at 2w, lower byte at 2w+1
  function automatic logic [ABITS-1:0] hi_idx(input logic [ABITS-1:0] w);
    hi_idx = {w[ABITS-2:0], 1'b0};
  endfunction
  function automatic logic [ABITS-1:0] lo_idx(input logic [ABITS-1:0] w);
    lo_idx = {w[ABITS-2:0], 1'b1};
  endfunction

  assign rd_word_o = org_i ? {mem[hi_idx(rd_addr_i)], mem[lo_idx(rd_addr_i)]}
                           : {8'h00, mem[rd_addr_i]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (we_i) begin
      case (kind_i)
        K_WRITE: begin
          if (org_i) begin
            mem[hi_idx(addr_i)] <= data_i[15:8];
            mem[lo_idx(addr_i)] <= data_i[7:0];
          end else begin
            mem[addr_i] <= data_i[7:0];
          end
        end
        K_ERASE: begin
          if (org_i) begin
            mem[hi_idx(addr_i)] <= 8'hFF;
            mem[lo_idx(addr_i)] <= 8'hFF;
          end else begin
            mem[addr_i] <= 8'hFF;
          end
        end
        K_CLEAR: for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
        K_FILL:  for (int i = 0; i < NBYTES; i++)
                   mem[i] <= (org_i && (i % 2 == 0)) ? data_i[15:8] : data_i[7:0];
        default: ;
      endcase
    end
  end

  AST_CLEAR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == K_CLEAR) |=> (rd_word_o[7:0] == 8'hFF)); // R11
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left <= '0;
    else if (go_i)          left <= CW'(PROG_CYCLES);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign busy_o = (left != '0);

  AST_TIMER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left <= CW'(PROG_CYCLES)); // R9
  AST_BUSY_FROM_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(go_i)); // R9
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ABITS       = 10,
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic do_o,
  output logic do_oe_o
);
  logic             sck_q, sck_rise;
  logic             start_ev, cmd_stb, rd_active, rd_bit, fr_idle;
  cmd_kind_t        cmd_kind;
  logic [ABITS-1:0] cmd_addr, rd_addr;
  logic [15:0]      cmd_data, rd_word;
  logic             wen_q, stat_arm, busy, prog_go, status_show;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end
  assign sck_rise = sck_i & ~sck_q & cs_i;

  mw_frame #(.ABITS(ABITS)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .sck_rise_i(sck_rise),
    .di_i(di_i), .org_i(org_i), .rd_word_i(rd_word),
    .start_o(start_ev), .cmd_stb_o(cmd_stb), .cmd_kind_o(cmd_kind),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .rd_addr_o(rd_addr),
    .rd_active_o(rd_active), .rd_bit_o(rd_bit), .idle_o(fr_idle)
  );

  assign prog_go = cmd_stb & is_prog(cmd_kind) & wen_q & pe_i & ~busy;

  mw_array #(.ABITS(ABITS)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .org_i(org_i), .we_i(prog_go),
    .kind_i(cmd_kind), .addr_i(cmd_addr), .data_i(cmd_data),
    .rd_addr_i(rd_addr), .rd_word_o(rd_word)
  );

  mw_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(prog_go), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q    <= 1'b0;
      stat_arm <= 1'b0;
    end else begin
      if (cmd_stb && cmd_kind == K_WEN)  wen_q <= 1'b1;
      if (cmd_stb && cmd_kind == K_WDIS) wen_q <= 1'b0;
      if (prog_go)       stat_arm <= 1'b1;
      else if (start_ev) stat_arm <= 1'b0;
    end
  end

  assign status_show = cs_i & stat_arm & fr_idle;
  assign do_oe_o     = cs_i & (rd_active | status_show);
  assign do_o        = rd_active ? rd_bit : ~busy;

  AST_DO_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !do_oe_o); // R8
  AST_PROG_NEEDS_PE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(pe_i)); // R6
  AST_PROG_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wen_q)); // R5
endmodule

// File: tb/mw_eeprom_slave_tb_top.sv
module mw_eeprom_slave_tb_top;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b0, pe = 1'b1;
  logic do_w, do_oe;
  int   checks = 0;
  int   errors = 0;

  logic [15:0] exp_v[$];
  string       exp_t[$];
  logic [15:0] obs_v[$];
  logic [15:0] m_a, m_e;
  string       m_t;

  always #2 clk = ~clk;

  mw_eeprom_slave #(.ABITS(10), .PROG_CYCLES(PROG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .org_i(org), .pe_i(pe), .do_o(do_w), .do_oe_o(do_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares observed read words against expected queue
  always @(negedge clk) begin
    while (obs_v.size() > 0 && exp_v.size() > 0) begin
      m_a = obs_v.pop_front();
      m_e = exp_v.pop_front();
      m_t = exp_t.pop_front();
      chk(m_a === m_e, m_t, m_a, m_e);
    end
  end

  task automatic expect_word(input logic [15:0] v, input string tag);
    exp_v.push_back(v);
    exp_t.push_back(tag);
  endtask

  task automatic sbit(input logic b, output logic d);
    @(negedge clk) di = b;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    d = do_oe ? do_w : 1'bz;
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic open_frame();
    @(negedge clk) cs = 1'b0; sck = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
    cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk) cs = 1'b0; di = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [10:0] sp(input logic [1:0] s);
    sp = org ? {1'b0, s, 8'h00} : {s, 9'h000};
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [10:0] fld, input logic [15:0] dat,
                     input bit has_dat, input bit wait_done);
    int aw;
    int dw;
    logic d;
    aw = org ? 10 : 11;
    dw = org ? 16 : 8;
    open_frame();
    sbit(1'b1, d); sbit(op[1], d); sbit(op[0], d);
    for (int i = aw - 1; i >= 0; i--) sbit(fld[i], d);
    if (has_dat) for (int i = dw - 1; i >= 0; i--) sbit(dat[i], d);
    close_frame();
    if (wait_done) repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] fld, input int nwords);
    int aw;
    int dw;
    logic d;
    logic [15:0] w;
    aw = org ? 10 : 11;
    dw = org ? 16 : 8;
    open_frame();
    sbit(1'b1, d); sbit(1'b1, d); sbit(1'b0, d);
    for (int i = aw - 1; i >= 0; i--) sbit(fld[i], d);
    chk(d === 1'b0, "R3 dummy zero", {15'd0, d}, 16'h0000);
    for (int k = 0; k < nwords; k++) begin
      w = 16'h0000;
      for (int b = 0; b < dw; b++) begin
        sbit(1'b0, d);
        w = {w[14:0], d};
      end
      obs_v.push_back(w);
    end
    close_frame();
  endtask

  initial begin : main
    logic d;
    repeat (4) @(negedge clk);
    chk(do_oe === 1'b0, "R8 reset released", {15'd0, do_oe}, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: clocks with data-in low while selected do nothing
    cs = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sbit(1'b0, d);
      chk(do_oe === 1'b0, "R1 idle clocks", {15'd0, do_oe}, 16'h0000);
    end
    cs = 1'b0;
    expect_word(16'h00FF, "R11 R12 reset contents");
    rd(11'd3, 1);

    // R5: write refused before enable
    cmd(2'b01, 11'd3, 16'h005A, 1, 1);
    expect_word(16'h00FF, "R5 write before enable");
    rd(11'd3, 1);

    // R10 status, R9 timing
    cmd(2'b00, sp(2'b11), 16'h0, 0, 0);
    cmd(2'b01, 11'd3, 16'h005A, 1, 0);
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
    chk(do_oe === 1'b1 && do_w === 1'b0, "R10 busy low", {14'd0, do_oe, do_w}, 16'h0002);
    repeat (PROG + 20) @(negedge clk);
    chk(do_oe === 1'b1 && do_w === 1'b1, "R9 ready after cycle", {14'd0, do_oe, do_w}, 16'h0003);
    sbit(1'b1, d);
    cs = 1'b0;
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
    chk(do_oe === 1'b0, "R10 status cleared", {15'd0, do_oe}, 16'h0000);
    cs = 1'b0;

    // R9: write during busy ignored
    cmd(2'b01, 11'd4, 16'h00C3, 1, 0);
    cmd(2'b01, 11'd5, 16'h0077, 1, 1);
    expect_word(16'h005A, "R2 write byte 3");
    expect_word(16'h00C3, "R3 sequential byte 4");
    expect_word(16'h00FF, "R9 busy write ignored");
    rd(11'd3, 3);

    // R4: 16-bit mode mapping
    org = 1'b1;
    expect_word(16'hFF5A, "R4 word 1 from bytes 2,3");
    rd(11'd1, 1);
    cmd(2'b01, 11'd1, 16'h1234, 1, 1);
    expect_word(16'h1234, "R4 word write");
    rd(11'd1, 1);
    org = 1'b0;
    expect_word(16'h0012, "R4 upper byte at 2w");
    expect_word(16'h0034, "R4 lower byte at 2w+1");
    rd(11'd2, 2);

    // R11: erase one location
    cmd(2'b11, 11'd3, 16'h0, 0, 1);
    expect_word(16'h00FF, "R11 erase");
    rd(11'd3, 1);

    // R3: wrap from last address
    cmd(2'b01, 11'd0, 16'h003C, 1, 1);
    expect_word(16'h00FF, "R3 last address");
    expect_word(16'h003C, "R3 wrap to zero");
    rd(11'd1023, 2);

    // R7: abort during data
    open_frame();
    sbit(1'b1, d); sbit(1'b0, d); sbit(1'b1, d);
    for (int i = 10; i >= 0; i--) sbit(((11'd7 >> i) & 11'd1) != 0, d);
    for (int i = 0; i < 4; i++) sbit(1'b0, d);
    close_frame();
    repeat (PROG + 20) @(negedge clk);
    expect_word(16'h00FF, "R7 abort leaves byte");
    rd(11'd7, 1);

    // R6: program enable low
    pe = 1'b0;
    cmd(2'b01, 11'd6, 16'h0011, 1, 0);
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
    chk(do_oe === 1'b0, "R6 no cycle started", {15'd0, do_oe}, 16'h0000);
    cs = 1'b0;
    pe = 1'b1;
    expect_word(16'h00FF, "R6 write blocked");
    rd(11'd6, 1);

    // R11: fill all and clear all
    cmd(2'b00, sp(2'b01), 16'h00A7, 1, 1);
    expect_word(16'h00A7, "R11 fill last");
    expect_word(16'h00A7, "R11 fill first");
    rd(11'd1023, 2);
    org = 1'b1;
    expect_word(16'hA7A7, "R11 fill 16-bit view");
    rd(11'd511, 1);
    org = 1'b0;
    cmd(2'b00, sp(2'b10), 16'h0, 0, 1);
    expect_word(16'h00FF, "R11 clear all");
    rd(11'd0, 1);

    // R5: disable again
    cmd(2'b00, sp(2'b00), 16'h0, 0, 0);
    cmd(2'b01, 11'd8, 16'h0055, 1, 1);
    expect_word(16'h00FF, "R5 write after disable");
    rd(11'd8, 1);

    // R8: select falling mid-read releases output
    open_frame();
    sbit(1'b1, d); sbit(1'b1, d); sbit(1'b0, d);
    for (int i = 0; i < 11; i++) sbit(1'b0, d);
    sbit(1'b0, d);
    @(negedge clk) cs = 1'b0;
    #1;
    chk(do_oe === 1'b0, "R8 release on deselect", {15'd0, do_oe}, 16'h0000);

    repeat (4) @(negedge clk);
    if (exp_v.size() != 0) chk(1'b0, "R3 missing read words", 16'(exp_v.size()), 16'h0000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", 16'h0000, 16'h0001);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule